// File: doc/BRIEF.md
# Column-Truncated Unsigned Array Multiplier

This block multiplies two unsigned operands of equal width using an explicit array: AND gates form the partial-product bits, and rows of half-adder and full-adder cells sum them. A parameter `DROP` sets how many of the lowest product columns are left out of the array. No AND gate, adder cell or carry is built for the partial-product bits whose weight falls in those columns. This reduces area at the cost of a bounded, one-sided error. Both operands enter at full precision. Only the array is cut, so every partial-product bit of weight 2^DROP or above keeps its exact contribution.

The result is registered once and keeps the full 2W-bit width. Product bits in the omitted columns are always zero. A second parameter `CORR` can add the constant CORR·2^DROP into the kept columns through one extra adder row, which re-centres the mean error. When `CORR` is zero, which is the default, that row is not built.

Top module: `trunc_array_mul`

## Requirements
- R1: While `rst_n` is low, `prod` is all zeros, whatever the operands are.
- R2: `prod` changes only on a rising clock edge. After an edge it reflects the operands sampled at that edge, giving exactly one cycle of latency.
- R3: With `DROP` = 0 and `CORR` = 0, `prod` equals the exact product a·b.
- R4: Bits `prod[DROP-1:0]` are always zero.
- R5: With `CORR` = 0, `prod` equals the sum of a[i]·b[j]·2^(i+j) over all index pairs with i+j ≥ DROP.
- R6: With `CORR` = 0, the error a·b − `prod` is never negative. It never exceeds Emax, the sum over every omitted column c < DROP of (number of partial-product bits in column c)·2^c. For W = 8, Emax is 5 when DROP = 2 and 17 when DROP = 3.
- R7: With `CORR` = 0, a zero operand gives `prod` = 0.
- R8: With `CORR` ≠ 0, `prod` equals the R5 sum plus CORR·2^DROP, taken modulo 2^(2W).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the result |
| a | input | W | Multiplicand, unsigned, full precision |
| b | input | W | Multiplier, unsigned, full precision |
| prod | output | 2W | Registered truncated product |

## Verification
On every cycle, the assertions check the following: reset clears the result; the omitted low bits stay zero; the result never exceeds the exact product of the previous operands and stays within Emax of it; a zero operand gives a zero result; and the result is exact when nothing is dropped. Some behaviour can only be shown by the bench scenarios, which compare several instances against a bench model built from the kept partial products. These cases are the bit-exact value of the truncated sum, the added correction term with its wrap-around, the output holding between edges, and the corner operands: all ones, single high bits, and values that fill only the omitted columns.

// File: rtl/trunc_array_mul.sv
module trunc_array_mul #(
  parameter int W    = 8,
  parameter int DROP = 2,
  parameter int CORR = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);

  localparam int PW  = 2 * W;
  localparam int NST = (CORR != 0) ? W + 1 : W;
  localparam logic [PW-1:0] CORR_V = PW'(CORR) << DROP;

  wire [PW-1:0] op  [NST];
  wire [PW-1:0] acc [NST];
  wire [PW-2:0] cy  [1:NST-1];

  genvar k, c;
  generate
    for (k = 0; k < W; k++) begin : g_row
      for (c = 0; c < PW; c++) begin : g_col
        if (c >= DROP && c >= k && c < k + W) begin : g_and
          assign op[k][c] = a[c-k] & b[k];
        end else begin : g_none
          assign op[k][c] = 1'b0;
        end
      end
    end

    if (CORR != 0) begin : g_corr
      assign op[W] = CORR_V;
    end

    assign acc[0] = op[0];

    for (k = 1; k < NST; k++) begin : g_stage
      for (c = 0; c < PW; c++) begin : g_cell
        if (c < DROP) begin : g_cut
          assign acc[k][c] = 1'b0;
          if (c < PW - 1) begin : g_cz
            assign cy[k][c] = 1'b0;
          end
        end else if (c == DROP) begin : g_ha
          assign acc[k][c] = acc[k-1][c] ^ op[k][c];
          if (c < PW - 1) begin : g_hc
            assign cy[k][c] = acc[k-1][c] & op[k][c];
          end
        end else begin : g_fa
          assign acc[k][c] = acc[k-1][c] ^ op[k][c] ^ cy[k][c-1];
          if (c < PW - 1) begin : g_fc
            assign cy[k][c] = (acc[k-1][c] & op[k][c]) |
                              (acc[k-1][c] & cy[k][c-1]) |
                              (op[k][c] & cy[k][c-1]);
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod <= '0;
    else        prod <= acc[NST-1];
  end

endmodule

// File: rtl/trunc_array_mul_chk.sv
module trunc_array_mul_chk #(
  parameter int W    = 8,
  parameter int DROP = 2,
  parameter int CORR = 0
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  function automatic longint emax_f();
    longint s;
    s = 0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (i + j < DROP) s += longint'(1) << (i + j);
    return s;
  endfunction

  localparam logic [PW-1:0] EMAX = PW'(emax_f());

  logic [PW-1:0] exact;
  assign exact = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (prod == '0)); // R1

  generate
    if (CORR == 0) begin : g_plain
      AST_NEVER_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prod <= $past(exact))); // R6
      AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(exact) - prod) <= EMAX)); // R6
      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (a == '0 || b == '0)) |=> (prod == '0)); // R7
    end
    if (CORR == 0 && DROP == 0) begin : g_full
      AST_EXACT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prod == $past(exact))); // R3
    end
    if (DROP > 0) begin : g_low
      AST_LOW_COLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prod[DROP-1:0] == '0)); // R4
    end
  endgenerate

endmodule

bind trunc_array_mul trunc_array_mul_chk #(.W(W), .DROP(DROP), .CORR(CORR)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(prod)
);

// File: tb/test_trunc_array_mul.sv
`timescale 1ns/1ps
module test_trunc_array_mul;
  localparam int W = 8;
  localparam int CV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [2*W-1:0] p3, p0, p2, pc;
  int checks = 0, errors = 0;
  logic [W-1:0] pa, pb;
  bit have_prev = 0;

  always #2 clk = ~clk;

  trunc_array_mul #(.W(W), .DROP(3), .CORR(0))  i_trunc_array_mul     (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(p3));
  trunc_array_mul #(.W(W), .DROP(0), .CORR(0))  i_trunc_array_mul_n0  (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(p0));
  trunc_array_mul #(.W(W), .DROP(2), .CORR(0))  i_trunc_array_mul_n2  (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(p2));
  trunc_array_mul #(.W(W), .DROP(4), .CORR(CV)) i_trunc_array_mul_cor (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(pc));

  function automatic longint kept_sum(logic [W-1:0] x, logic [W-1:0] y, int drop);
    longint s = 0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (i + j >= drop && x[i] && y[j]) s += longint'(1) << (i + j);
    return s;
  endfunction

  function automatic longint emax(int drop);
    longint s = 0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (i + j < drop) s += longint'(1) << (i + j);
    return s;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y);
    longint ex;
    @(negedge clk);
    a = x; b = y;
    #1;
    if (have_prev) chk("R2 hold", longint'(p3), kept_sum(pa, pb, 3));
    @(negedge clk);
    ex = longint'(x) * longint'(y);
    chk("R5 drop3", longint'(p3), kept_sum(x, y, 3));
    chk("R5 drop2", longint'(p2), kept_sum(x, y, 2));
    chk("R3 exact", longint'(p0), ex);
    chk("R8 corr", longint'(pc), (kept_sum(x, y, 4) + (CV << 4)) & 64'hFFFF);
    chk("R4 low bits", longint'({p3[2:0], p2[1:0], pc[3:0]}), 0);
    chk_range("R6 err drop3", ex - longint'(p3), 0, emax(3));
    chk_range("R6 err drop2", ex - longint'(p2), 0, emax(2));
    if (x == '0 || y == '0) chk("R7 zero operand", longint'({p3, p2}), 0);
    pa = x; pb = y; have_prev = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    a = 8'hFF; b = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset", longint'({p3, p0}), 0);
    chk("R1 reset", longint'({p2, pc}), 0);
    rst_n = 1'b1;
    apply(8'h00, 8'hFF);
    apply(8'hA5, 8'h00);
    apply(8'hFF, 8'hFF);
    apply(8'h01, 8'h01);
    apply(8'h03, 8'h03);
    apply(8'h80, 8'h80);
    apply(8'h07, 8'h01);
    apply(8'h01, 8'h80);
    apply(8'hFF, 8'h01);
    for (int n = 0; n < 300; n++) apply(W'($urandom), W'($urandom));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", longint'({p3, pc}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule